// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a 16-bit selector and a 32-bit offset into a 32-bit linear address. A selector load picks one of two descriptor tables, fetches the selected 8-byte descriptor through a plain memory read port, and checks it. If the descriptor is usable, its base, effective limit and check mode are kept in a one-entry segment cache. Every later access is checked against that cache in one registered cycle. The access either returns base plus offset or reports a fault.

The global table's base and byte limit come in on ports. The local table has no fixed location. A separate load kind takes a selector into the global table, fetches a system descriptor from there, and keeps its base and effective limit as the local-table register. After that, selectors with the table bit set are resolved through that table. Privilege comparison, task switching and paging belong to other blocks.

Top module: `seg_xlate_top`

## Requirements
- R1: The selector holds the descriptor index in bits 15:3 and the table bit in bit 2 (0 = global, 1 = local). The descriptor address is the table base plus the index times 8. It is read as two 32-bit words, the low word at that address and the high word at that address plus 4.
- R2: A load whose last descriptor byte (index*8+7) lies above the chosen table's limit ends with fault code 2 (general protection) and issues no memory read. A local-table selector used before any local table is loaded also ends with fault code 2.
- R3: The descriptor fields sit at fixed positions. In the low word, bits 15:0 hold limit 15:0 and bits 31:16 hold base 15:0. In the high word, bits 7:0 hold base 23:16, 11:8 the type, 12 the S bit, 15 the present bit, 19:16 limit 19:16, 22 the D/B bit, 23 the granularity bit and 31:24 base 31:24.
- R4: A fetched descriptor with the present bit clear ends the load with fault code 1 (not present), and the cached segment or local table keeps its previous contents.
- R5: With the granularity bit clear the effective limit is the 20-bit limit in bytes. With it set the effective limit is the limit shifted left by 12 with the low 12 bits all ones.
- R6: For expand-up segments, an offset at or below the effective limit is valid and a larger one faults. Every segment whose type bit 3 is set (code), or whose type bit 2 is clear, is expand-up.
- R7: A data segment (S set, type bit 3 clear) with type bit 2 set is expand-down. It accepts only offsets above the effective limit and no higher than 0xFFFF (D/B clear) or 0xFFFFFFFF (D/B set).
- R8: An access presented with acc_valid gives acc_done one cycle later. When the access is valid, acc_lin is the cached base plus the offset, modulo 2^32.
- R9: Load kind 1 loads the local-table register. It faults with code 2 if the selector's table bit is set or if the descriptor has S set. Load kind 0 loads a segment and faults with code 2 if the descriptor has S clear.
- R10: busy rises the cycle after a load that needs a fetch is accepted. It stays high until the edge on which ld_done reports the result. A load presented while busy is high is ignored.
- R11: Reset clears busy, ld_done, acc_done and mem_req_valid, and empties the segment cache. Any access made while no segment is cached faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table byte limit |
| ld_valid | input | 1 | Load request |
| ld_kind | input | 1 | 0 = segment load, 1 = local-table load |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse ending a load |
| ld_fault | output | 2 | Load result: 0 ok, 1 not present, 2 general protection |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| acc_valid | input | 1 | Access request |
| acc_offset | input | 32 | Access offset |
| acc_done | output | 1 | Access result valid |
| acc_fault | output | 1 | Access limit or empty-cache fault |
| acc_lin | output | 32 | Linear address (zero on fault) |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, and only after that request. They also assume that the inputs are driven to zero during reset. The bench's memory model answers one cycle after each accepted request and never responds unprompted. The bench holds ld_valid and acc_valid low throughout reset. It stalls mem_req_ready only in the busy scenario, where the request-hold property is exercised.

// File: rtl/segx_pkg.sv
// segx_pkg: shared types and helpers for the segment translator.
// Assumes the fixed 8-byte descriptor layout described in the brief (R3).
package segx_pkg;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_GENERAL     = 2'd2
    } fault_e;

    // Decoded descriptor fields
    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic [3:0]  kind;
        logic        user_seg;   // S bit
        logic        present;
        logic        big;        // D/B bit
        logic        gran;
    } desc_t;

    // Cached segment or local table view
    typedef struct packed {
        logic        valid;
        logic [31:0] base;
        logic [31:0] lim;
        logic        expand_down;
        logic        big;
    } seg_cache_t;

    // Split the two fetched words into fields (R3)
    function automatic desc_t desc_unpack(input logic [63:0] raw);
        desc_t d;
        d.base     = {raw[63:56], raw[39:32], raw[31:16]};
        d.limit    = {raw[51:48], raw[15:0]};
        d.kind     = raw[43:40];
        d.user_seg = raw[44];
        d.present  = raw[47];
        d.big      = raw[54];
        d.gran     = raw[55];
        return d;
    endfunction

    // Scale the raw limit by granularity (R5)
    function automatic logic [31:0] eff_limit(input logic [19:0] lim, input logic gran);
        return gran ? {lim, 12'hFFF} : {12'h000, lim};
    endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
// seg_desc_fetch: reads one 8-byte descriptor as two words over a
// valid/ready request port with a one-word response port.
// Assumes one response per accepted request, in order.
module seg_desc_fetch #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    output logic            desc_vld,
    output logic [2*DW-1:0] desc_raw
);
    localparam int STEP = DW / 8;

    typedef enum logic [2:0] {F_IDLE, F_REQ_LO, F_WAIT_LO, F_REQ_HI, F_WAIT_HI} fstate_e;

    fstate_e       st;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] lo_q;

    // Sequence the two reads and capture both words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= F_IDLE;
            addr_q   <= '0;
            lo_q     <= '0;
            desc_vld <= 1'b0;
            desc_raw <= '0;
        end else begin
            desc_vld <= 1'b0;
            case (st)
                F_IDLE: if (start) begin
                    addr_q <= start_addr;
                    st     <= F_REQ_LO;
                end
                F_REQ_LO: if (mem_req_ready) st <= F_WAIT_LO;
                F_WAIT_LO: if (mem_rsp_valid) begin
                    lo_q   <= mem_rsp_data;
                    addr_q <= addr_q + AW'(STEP);
                    st     <= F_REQ_HI;
                end
                F_REQ_HI: if (mem_req_ready) st <= F_WAIT_HI;
                F_WAIT_HI: if (mem_rsp_valid) begin
                    desc_raw <= {mem_rsp_data, lo_q};
                    desc_vld <= 1'b1;
                    st       <= F_IDLE;
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Request is valid in the two request states only
    always_comb begin
        mem_req_valid = (st == F_REQ_LO) || (st == F_REQ_HI);
        mem_req_addr  = addr_q;
    end

endmodule

// File: rtl/seg_sel_check.sv
// seg_sel_check: picks the table for a selector, forms the descriptor
// address and flags general-protection cases (R1, R2, R9).
// Assumes the selector index occupies bits SW-1:3 and the table bit is bit 2.
module seg_sel_check #(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int GLW = 16
) (
    input  logic [SW-1:0]  sel,
    input  logic           kind_ldt,
    input  logic [AW-1:0]  gbase,
    input  logic [GLW-1:0] glim,
    input  logic           ldt_ok,
    input  logic [AW-1:0]  ldt_base,
    input  logic [AW-1:0]  ldt_lim,
    output logic [AW-1:0]  desc_addr,
    output logic           gp
);
    localparam int IW = SW - 3;

    logic [IW-1:0] idx;
    logic          use_local;
    logic [AW-1:0] tbase;
    logic [AW-1:0] tlim;
    logic [AW-1:0] last_byte;

    // Table choice, address and bound test
    always_comb begin
        idx       = sel[SW-1:3];
        use_local = sel[2] && !kind_ldt;
        tbase     = use_local ? ldt_base : gbase;
        tlim      = use_local ? ldt_lim : AW'(glim);
        last_byte = AW'({idx, 3'b111});
        desc_addr = tbase + AW'({idx, 3'b000});
        gp        = (kind_ldt && sel[2]) || (use_local && !ldt_ok) || (last_byte > tlim);
    end

endmodule

// File: rtl/seg_limit_check.sv
// seg_limit_check: tests an offset against a cached limit in either
// expand-up or expand-down mode (R6, R7). Purely combinational.
module seg_limit_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] lim,
    input  logic          expand_down,
    input  logic          big,
    output logic          in_range
);
    localparam logic [AW-1:0] SMALL_TOP = AW'(16'hFFFF);
    localparam logic [AW-1:0] BIG_TOP   = '1;

    logic [AW-1:0] upper;

    // Choose bound and compare
    always_comb begin
        upper = big ? BIG_TOP : SMALL_TOP;
        if (expand_down) in_range = (offset > lim) && (offset <= upper);
        else             in_range = (offset <= lim);
    end

endmodule

// File: rtl/seg_xlate_top.sv
// seg_xlate_top: selector load control, segment cache, local-table
// register and registered access path.
// Assumes loads are single-cycle pulses and memory answers every request.
module seg_xlate_top #(
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int GLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  gtab_base,
    input  logic [GLW-1:0] gtab_limit,
    input  logic           ld_valid,
    input  logic           ld_kind,
    input  logic [SW-1:0]  ld_sel,
    output logic           busy,
    output logic           ld_done,
    output logic [1:0]     ld_fault,
    output logic           mem_req_valid,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_req_ready,
    input  logic           mem_rsp_valid,
    input  logic [31:0]    mem_rsp_data,
    input  logic           acc_valid,
    input  logic [AW-1:0]  acc_offset,
    output logic           acc_done,
    output logic           acc_fault,
    output logic [AW-1:0]  acc_lin
);
    import segx_pkg::*;

    seg_cache_t    seg_q;
    seg_cache_t    ldt_q;
    logic          busy_q;
    logic          kind_q;
    logic          accept;
    logic          sel_gp;
    logic [AW-1:0] desc_addr;
    logic          desc_vld;
    logic [63:0]   desc_raw;
    desc_t         dd;
    logic          in_range;
    fault_e        fault_q;

    seg_sel_check #(.AW(AW), .SW(SW), .GLW(GLW)) u_sel (
        .sel       (ld_sel),
        .kind_ldt  (ld_kind),
        .gbase     (gtab_base),
        .glim      (gtab_limit),
        .ldt_ok    (ldt_q.valid),
        .ldt_base  (ldt_q.base),
        .ldt_lim   (ldt_q.lim),
        .desc_addr (desc_addr),
        .gp        (sel_gp)
    );

    seg_desc_fetch #(.AW(AW), .DW(32)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept && !sel_gp),
        .start_addr    (desc_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .desc_vld      (desc_vld),
        .desc_raw      (desc_raw)
    );

    seg_limit_check #(.AW(AW)) u_lim (
        .offset      (acc_offset),
        .lim         (seg_q.lim),
        .expand_down (seg_q.expand_down),
        .big         (seg_q.big),
        .in_range    (in_range)
    );

    // Load acceptance and descriptor decode
    always_comb begin
        accept = ld_valid && !busy_q;
        dd     = desc_unpack(desc_raw);
    end

    // Load control, result reporting and cache/local-table updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            kind_q  <= 1'b0;
            ld_done <= 1'b0;
            fault_q <= FLT_NONE;
            seg_q   <= '0;
            ldt_q   <= '0;
        end else begin
            ld_done <= 1'b0;
            fault_q <= FLT_NONE;
            if (accept) begin
                if (sel_gp) begin
                    ld_done <= 1'b1;
                    fault_q <= FLT_GENERAL;
                end else begin
                    busy_q <= 1'b1;
                    kind_q <= ld_kind;
                end
            end
            if (desc_vld) begin
                busy_q  <= 1'b0;
                ld_done <= 1'b1;
                if (!dd.present) begin
                    fault_q <= FLT_NOT_PRESENT;
                end else if (kind_q == dd.user_seg) begin
                    fault_q <= FLT_GENERAL;
                end else if (kind_q) begin
                    ldt_q.valid       <= 1'b1;
                    ldt_q.base        <= dd.base;
                    ldt_q.lim         <= eff_limit(dd.limit, dd.gran);
                    ldt_q.expand_down <= 1'b0;
                    ldt_q.big         <= dd.big;
                end else begin
                    seg_q.valid       <= 1'b1;
                    seg_q.base        <= dd.base;
                    seg_q.lim         <= eff_limit(dd.limit, dd.gran);
                    seg_q.expand_down <= !dd.kind[3] && dd.kind[2];
                    seg_q.big         <= dd.big;
                end
            end
        end
    end

    // Registered access result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_done  <= 1'b0;
            acc_fault <= 1'b0;
            acc_lin   <= '0;
        end else begin
            acc_done  <= acc_valid;
            acc_fault <= acc_valid && !(seg_q.valid && in_range);
            acc_lin   <= (acc_valid && seg_q.valid && in_range) ? seg_q.base + acc_offset : '0;
        end
    end

    // Drive outputs
    always_comb begin
        busy     = busy_q;
        ld_fault = fault_q;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
// seg_xlate_chk: port-level properties of seg_xlate_top, bound below.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ld_done,
    input logic [1:0]  ld_fault,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        acc_valid,
    input logic        acc_done,
    input logic        acc_fault,
    input logic [31:0] acc_lin
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R10
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ld_done); // R10
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fault != 2'd0) |-> ld_done); // R4
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault != 2'd3); // R2
    AST_ACC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> acc_done); // R8
    AST_ACC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !acc_done); // R8
    AST_FAULT_ZERO_LIN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_done && acc_lin == 32'd0); // R11
endmodule

bind seg_xlate_top seg_xlate_chk u_chk (.*);

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] gtab_base = 32'h100;
    logic [15:0] gtab_limit = 16'h3F;
    logic        ld_valid = 0, ld_kind = 0;
    logic [15:0] ld_sel = 0;
    logic        busy, ld_done;
    logic [1:0]  ld_fault;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;
    logic        acc_valid = 0;
    logic [31:0] acc_offset = 0;
    logic        acc_done, acc_fault;
    logic [31:0] acc_lin;

    logic [31:0] mem [0:255];
    logic        mem_ready = 1;
    int          req_cnt = 0;
    logic [31:0] prev_addr = 0, last_addr = 0;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    seg_xlate_top dut (.*);

    assign mem_req_ready = mem_ready;

    // Memory model: one-cycle read latency, logs request addresses
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[9:2]];
            prev_addr = last_addr;
            last_addr = mem_req_addr;
            req_cnt++;
        end
    end

    function automatic [31:0] dlo(input [31:0] b, input [19:0] l);
        return {b[15:0], l[15:0]};
    endfunction
    function automatic [31:0] dhi(input [31:0] b, input [19:0] l, input [3:0] t,
                                  input s, input p, input db, input g);
        return {b[31:24], g, db, 2'b00, l[19:16], p, 2'b00, s, t, b[23:16]};
    endfunction
    task automatic put(input int word, input [31:0] b, input [19:0] l, input [3:0] t,
                       input s, input p, input db, input g);
        mem[word]   = dlo(b, l);
        mem[word+1] = dhi(b, l, t, s, p, db, g);
    endtask

    task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic kind, input [15:0] sel, output [1:0] code);
        int n = 0;
        while (busy) @(negedge clk);
        ld_valid = 1; ld_kind = kind; ld_sel = sel;
        @(negedge clk);
        ld_valid = 0;
        while (!ld_done && n < 100) begin @(negedge clk); n++; end
        code = ld_done ? ld_fault : 2'b11;
    endtask

    task automatic access(input [31:0] off, output logic f, output [31:0] lin);
        acc_valid = 1; acc_offset = off;
        @(negedge clk);
        acc_valid = 0;
        f = acc_fault; lin = acc_lin;
        if (!acc_done) begin f = 1'bx; end
    endtask

    task automatic exp_ok(input [31:0] off, input [31:0] lin_e, input string req);
        logic f; logic [31:0] lin;
        access(off, f, lin);
        chk(f === 1'b0 && lin == lin_e, req, lin, lin_e);
    endtask
    task automatic exp_flt(input [31:0] off, input string req);
        logic f; logic [31:0] lin;
        access(off, f, lin);
        chk(f === 1'b1, req, {31'd0, f}, 32'd1);
    endtask
    task automatic exp_load(input logic kind, input [15:0] sel, input [1:0] e, input string req);
        logic [1:0] c;
        load(kind, sel, c);
        chk(c == e, req, {30'd0, c}, {30'd0, e});
    endtask

    task automatic t_reset;
        chk(!busy && !ld_done && !acc_done && !mem_req_valid, "R11 reset outputs",
            {28'd0, busy, ld_done, acc_done, mem_req_valid}, 0);
        exp_flt(32'h0, "R11 access with empty cache");
    endtask

    task automatic t_global_load;
        exp_load(0, 16'h0008, 2'd0, "R1 global load ok");
        chk(prev_addr == 32'h108 && last_addr == 32'h10C, "R1 read addresses", prev_addr, 32'h108);
        exp_ok(32'h10, 32'hA1B2C3E0, "R3 R8 base plus offset");
        exp_ok(32'hFFF, 32'hA1B2D3CF, "R6 offset at limit");
        exp_flt(32'h1000, "R6 offset above limit");
    endtask

    task automatic t_not_present;
        exp_load(0, 16'h0010, 2'd1, "R4 not present");
        exp_ok(32'h10, 32'hA1B2C3E0, "R4 cache kept");
    endtask

    task automatic t_bounds;
        int c0 = req_cnt;
        exp_load(0, 16'h0040, 2'd2, "R2 index beyond global limit");
        chk(req_cnt == c0, "R2 no read on bound fault", req_cnt, c0);
        exp_load(0, 16'h0004, 2'd2, "R2 local selector with no local table");
        exp_load(0, 16'h0018, 2'd2, "R9 segment load of system descriptor");
        exp_ok(32'h10, 32'hA1B2C3E0, "R9 cache kept after type fault");
    endtask

    task automatic t_local;
        exp_load(1, 16'h0008, 2'd2, "R9 local load of data descriptor");
        exp_load(1, 16'h001C, 2'd2, "R9 local load with table bit set");
        exp_load(1, 16'h0018, 2'd0, "R9 local load ok");
        exp_load(0, 16'h0004, 2'd0, "R1 local segment load");
        chk(prev_addr == 32'h200 && last_addr == 32'h204, "R1 local read addresses", prev_addr, 32'h200);
        exp_ok(32'hF, 32'h5000000F, "R8 local segment address");
        exp_flt(32'h10, "R6 local segment limit");
        exp_load(0, 16'h001C, 2'd2, "R2 index beyond local limit");
        exp_load(0, 16'h000C, 2'd1, "R4 local not present");
        exp_ok(32'hF, 32'h5000000F, "R4 local cache kept");
        exp_load(0, 16'h0014, 2'd0, "R6 code segment load");
        exp_ok(32'h50, 32'h750, "R6 code with type bit 2 stays expand-up");
        exp_flt(32'h101, "R6 code above limit");
    endtask

    task automatic t_gran;
        exp_load(0, 16'h0020, 2'd0, "R5 granular load");
        exp_ok(32'h3FFF, 32'h40003FFF, "R5 scaled limit top");
        exp_flt(32'h4000, "R5 past scaled limit");
    endtask

    task automatic t_expand_down;
        exp_load(0, 16'h0028, 2'd0, "R7 small expand-down load");
        exp_flt(32'hFFF, "R7 offset at limit faults");
        exp_ok(32'h1000, 32'h3000, "R7 just above limit");
        exp_ok(32'hFFFF, 32'h11FFF, "R7 small upper bound");
        exp_flt(32'h10000, "R7 above small upper bound");
        exp_load(0, 16'h0030, 2'd0, "R7 big expand-down load");
        exp_flt(32'hFFFF, "R7 big at limit faults");
        exp_ok(32'h10000, 32'h12000, "R7 big above limit");
        exp_ok(32'hFFFFFFFF, 32'h1FFF, "R8 address wraps");
    endtask

    task automatic t_busy;
        int n = 0;
        mem_ready = 0;
        ld_valid = 1; ld_kind = 0; ld_sel = 16'h0008;
        @(negedge clk);
        ld_valid = 0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R10 busy while fetch stalls", busy, 1);
        ld_valid = 1; ld_sel = 16'h0010;
        @(negedge clk);
        ld_valid = 0;
        mem_ready = 1;
        while (!ld_done && n < 100) begin @(negedge clk); n++; end
        chk(ld_done && ld_fault == 2'd0 && !busy, "R10 first load completes",
            {30'd0, ld_fault}, 0);
        n = 0;
        repeat (10) begin @(negedge clk); if (ld_done) n++; end
        chk(n == 0, "R10 load while busy ignored", n, 0);
        exp_ok(32'h10, 32'hA1B2C3E0, "R10 cache from first load");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        put(66, 32'hA1B2C3D0, 20'h00FFF, 4'b0010, 1, 1, 0, 0);
        put(68, 32'h00000000, 20'h00FFF, 4'b0010, 1, 0, 0, 0);
        put(70, 32'h00000200, 20'h00017, 4'b0010, 0, 1, 0, 0);
        put(72, 32'h40000000, 20'h00003, 4'b0010, 1, 1, 0, 1);
        put(74, 32'h00002000, 20'h00FFF, 4'b0110, 1, 1, 0, 0);
        put(76, 32'h00002000, 20'h0FFFF, 4'b0110, 1, 1, 1, 0);
        put(128, 32'h50000000, 20'h0000F, 4'b0010, 1, 1, 0, 0);
        put(130, 32'h50000000, 20'h0000F, 4'b0010, 1, 0, 0, 0);
        put(132, 32'h00000700, 20'h00100, 4'b1110, 1, 1, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_global_load;
        t_not_present;
        t_bounds;
        t_local;
        t_gran;
        t_expand_down;
        t_busy;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule